// File: doc/BRIEF.md
# PHY Power-Up Calibration Sequencer

This block is a hardware state machine that takes a storage-interface PHY from a powered-down state to a usable one, or back down. Each request, whether it is power-on or power-off, first pulls the power-down release line and the DLL enable line low. A power-off request stops there and reports success.

A power-on request then holds both lines low for a settle interval, so that the pad calibration logic can initialise. It releases power-down and waits, with a microsecond-scale timeout, for the calibration-done status. Once calibration is done it drives a DLL frequency band chosen from the card-clock rate that was captured with the request. One cycle later it enables the DLL. It then waits, with a millisecond-scale timeout, for the DLL-ready status. When the captured rate is zero, no lock can happen, so the sequence finishes as soon as the DLL is enabled. All times are counted in cycles of the reference clock, whose cycles-per-microsecond is a parameter.

Top module: `phyup_seq`

## Requirements
- R1: After reset, `pwr_up`, `dll_en`, `freq_band`, `rate_warn`, `done`, `err` and `err_code` are all 0.
- R2: A power-off request (`req_valid`=1, `req_on`=0) accepted in idle drives `pwr_up` and `dll_en` to 0 and pulses `done` with `err_code`=0 in the cycle after acceptance. No other output changes.
- R3: A power-on request drives `pwr_up` and `dll_en` to 0 in the cycle after acceptance. `pwr_up` rises exactly SETTLE_US*REF_CYC_PER_US cycles after the accepting edge.
- R4: The band code is derived from `rate_hz` as follows: 1 for 1 to 74,999,999; 2 for 75,000,000 to 124,999,999; 3 for 125,000,000 to 174,999,999; 0 for 175,000,000 and above and for 0.
- R5: `rate_warn` is updated on power-on acceptance. It is 1 when the rate exceeds 200 MHz, or when the rate exceeds 50 MHz and differs from its band centre (50/100/150/200 MHz for codes 1/2/3/0) by more than 15 MHz. A power-off acceptance clears it.
- R6: If `cal_done` is not seen within CAL_TO_US*REF_CYC_PER_US cycles after `pwr_up` rises, `err` pulses with `err_code`=1 exactly that many cycles after the rise, and `dll_en` stays 0.
- R7: When `cal_done` is seen, `freq_band` takes the band code on the next edge. `dll_en` rises one cycle after that, and `freq_band` holds while the DLL is enabled.
- R8: When the captured rate is 0, `done` pulses with `err_code`=0 in the same cycle that `dll_en` rises, and `dll_ready` is not waited for.
- R9: With a nonzero rate, `done` pulses one cycle after `dll_ready` is seen. If it is not seen within LOCK_TO_MS*1000*REF_CYC_PER_US cycles after `dll_en` rises, `err` pulses with `err_code`=2 at exactly that count.
- R10: A request presented while a sequence is running is ignored: its timing and results are unchanged.
- R11: `done` and `err` are one-cycle pulses and are never high together. `err_code` is nonzero only with `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only in idle |
| req_on | input | 1 | 1 = power on, 0 = power off |
| rate_hz | input | 32 | Card-clock rate in Hz, captured with the request |
| cal_done | input | 1 | Pad calibration finished |
| dll_ready | input | 1 | DLL locked |
| pwr_up | output | 1 | Power-down release (1 = powered) |
| dll_en | output | 1 | DLL enable |
| freq_band | output | 2 | DLL frequency band code |
| rate_warn | output | 1 | Captured rate is out of tolerance |
| done | output | 1 | Success pulse |
| err | output | 1 | Failure pulse |
| err_code | output | 2 | 0 none, 1 calibration timeout, 2 lock timeout |

## Verification
The assertions assume the following about the inputs:
- The settle, calibration and lock intervals are each at least one cycle.
- The status inputs are synchronous to the reference clock.

The bench honours both points. It builds the block with small timing parameters, so that every timeout completes in a few thousand cycles. It changes `cal_done`, `dll_ready` and the request lines only on the falling clock edge. It clears both status inputs before each new request.

// File: rtl/phyup_pkg.sv
// Package: shared state and result encodings for the PHY power-up sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package phyup_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_CAL    = 3'd2,
        ST_BAND   = 3'd3,
        ST_LOCK   = 3'd4
    } seq_state_t;

    typedef enum logic [1:0] {
        RES_OK       = 2'd0,
        RES_CAL_TMO  = 2'd1,
        RES_LOCK_TMO = 2'd2
    } result_t;

endpackage

// File: rtl/phyup_band_map.sv
// Module: phyup_band_map
// Maps a card-clock rate in Hz to a DLL band code. It also flags rates that
// sit too far from the band centre or above the top band.
// Assumes: RATE_W is wide enough to hold 200 MHz plus tolerance.
module phyup_band_map #(
    parameter int RATE_W = 32
) (
    input  logic [RATE_W-1:0] rate,
    output logic [1:0]        band,
    output logic              warn,
    output logic              is_zero
);
    localparam logic [RATE_W-1:0] EDGE_1   = RATE_W'(75_000_000);
    localparam logic [RATE_W-1:0] EDGE_2   = RATE_W'(125_000_000);
    localparam logic [RATE_W-1:0] EDGE_3   = RATE_W'(175_000_000);
    localparam logic [RATE_W-1:0] MHZ_50   = RATE_W'(50_000_000);
    localparam logic [RATE_W-1:0] MHZ_100  = RATE_W'(100_000_000);
    localparam logic [RATE_W-1:0] MHZ_150  = RATE_W'(150_000_000);
    localparam logic [RATE_W-1:0] MHZ_200  = RATE_W'(200_000_000);
    localparam logic [RATE_W-1:0] TOL      = RATE_W'(15_000_000);

    logic [RATE_W-1:0] centre;
    logic [RATE_W-1:0] delta;

    // Band selection and centre frequency from the rate.
    always_comb begin
        is_zero = (rate == '0);
        if (is_zero) begin
            band   = 2'd0;
            centre = MHZ_200;
        end else if (rate < EDGE_1) begin
            band   = 2'd1;
            centre = MHZ_50;
        end else if (rate < EDGE_2) begin
            band   = 2'd2;
            centre = MHZ_100;
        end else if (rate < EDGE_3) begin
            band   = 2'd3;
            centre = MHZ_150;
        end else begin
            band   = 2'd0;
            centre = MHZ_200;
        end
    end

    // Tolerance check against the band centre.
    always_comb begin
        delta = (rate > centre) ? (rate - centre) : (centre - rate);
        warn  = ((rate > MHZ_50) && (delta > TOL)) || (rate > MHZ_200);
    end

endmodule

// File: rtl/phyup_timer.sv
// Module: phyup_timer
// Loadable down-counter shared by the settle, calibration and lock waits.
// Assumes: load values are at least 1. The owner never decrements on the
// last count.
module phyup_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    // Count register: a load takes priority over a decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == CNT_W'(1));

    // The owner never decrements an empty counter (R3, R6, R9 windows).
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt != '0));

    // A load value is never zero (R3).
    p_load_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

endmodule

// File: rtl/phyup_seq.sv
// Module: phyup_seq (top)
// Sequences PHY power-up: force the lines low, settle, release power-down,
// wait for calibration, set the DLL band, enable the DLL, then wait for lock.
// Power-off requests only force the lines low.
// Assumes: status inputs are synchronous to clk. The timing parameters are
// all at least 1.
module phyup_seq #(
    parameter int REF_CYC_PER_US = 100,
    parameter int SETTLE_US      = 3,
    parameter int CAL_TO_US      = 50,
    parameter int LOCK_TO_MS     = 50,
    parameter int RATE_W         = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_on,
    input  logic [RATE_W-1:0] rate_hz,
    input  logic              cal_done,
    input  logic              dll_ready,
    output logic              pwr_up,
    output logic              dll_en,
    output logic [1:0]        freq_band,
    output logic              rate_warn,
    output logic              done,
    output logic              err,
    output logic [1:0]        err_code
);
    import phyup_pkg::*;

    localparam int SETTLE_CYC = SETTLE_US * REF_CYC_PER_US;
    localparam int CAL_CYC    = CAL_TO_US * REF_CYC_PER_US;
    localparam int LOCK_CYC   = LOCK_TO_MS * 1000 * REF_CYC_PER_US;
    localparam int MAX_CYC    = (LOCK_CYC > CAL_CYC) ?
                                ((LOCK_CYC > SETTLE_CYC) ? LOCK_CYC : SETTLE_CYC) :
                                ((CAL_CYC > SETTLE_CYC) ? CAL_CYC : SETTLE_CYC);
    localparam int CNT_W      = $clog2(MAX_CYC + 1);

    seq_state_t       st;
    logic [1:0]       band_q;
    logic             zero_q;
    logic [1:0]       band_c;
    logic             warn_c;
    logic             zero_c;
    logic             t_load;
    logic             t_dec;
    logic             t_last;
    logic [CNT_W-1:0] t_val;

    phyup_band_map #(.RATE_W(RATE_W)) u_band (
        .rate    (rate_hz),
        .band    (band_c),
        .warn    (warn_c),
        .is_zero (zero_c)
    );

    phyup_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .dec      (t_dec),
        .last     (t_last)
    );

    // Timer control: which interval to load, and when to count down.
    always_comb begin
        t_load = 1'b0;
        t_dec  = 1'b0;
        t_val  = CNT_W'(SETTLE_CYC);
        case (st)
            ST_IDLE: begin
                t_load = req_valid && req_on;
                t_val  = CNT_W'(SETTLE_CYC);
            end
            ST_SETTLE: begin
                t_load = t_last;
                t_dec  = !t_last;
                t_val  = CNT_W'(CAL_CYC);
            end
            ST_CAL:  t_dec = !cal_done && !t_last;
            ST_BAND: begin
                t_load = !zero_q;
                t_val  = CNT_W'(LOCK_CYC);
            end
            ST_LOCK: t_dec = !dll_ready && !t_last;
            default: ;
        endcase
    end

    // Main sequence: state, PHY control lines and result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            pwr_up    <= 1'b0;
            dll_en    <= 1'b0;
            freq_band <= 2'd0;
            rate_warn <= 1'b0;
            band_q    <= 2'd0;
            zero_q    <= 1'b0;
            done      <= 1'b0;
            err       <= 1'b0;
            err_code  <= RES_OK;
        end else begin
            done     <= 1'b0;
            err      <= 1'b0;
            err_code <= RES_OK;
            case (st)
                ST_IDLE: if (req_valid) begin
                    pwr_up <= 1'b0;
                    dll_en <= 1'b0;
                    if (req_on) begin
                        band_q    <= band_c;
                        zero_q    <= zero_c;
                        rate_warn <= warn_c;
                        st        <= ST_SETTLE;
                    end else begin
                        rate_warn <= 1'b0;
                        done      <= 1'b1;
                    end
                end
                ST_SETTLE: if (t_last) begin
                    pwr_up <= 1'b1;
                    st     <= ST_CAL;
                end
                ST_CAL: if (cal_done) begin
                    freq_band <= band_q;
                    st        <= ST_BAND;
                end else if (t_last) begin
                    err      <= 1'b1;
                    err_code <= RES_CAL_TMO;
                    st       <= ST_IDLE;
                end
                ST_BAND: begin
                    dll_en <= 1'b1;
                    if (zero_q) begin
                        done <= 1'b1;
                        st   <= ST_IDLE;
                    end else begin
                        st <= ST_LOCK;
                    end
                end
                ST_LOCK: if (dll_ready) begin
                    done <= 1'b1;
                    st   <= ST_IDLE;
                end else if (t_last) begin
                    err      <= 1'b1;
                    err_code <= RES_LOCK_TMO;
                    st       <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // The DLL is only enabled while the PHY is powered (R7).
    p_dll_needs_pwr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dll_en |-> pwr_up);

    // The band does not move while waiting for lock (R7).
    p_band_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOCK) |-> $stable(freq_band));

    // The lines stay low during the settle interval (R3).
    p_settle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SETTLE) |-> (!pwr_up && !dll_en));

    // Success and failure never coincide (R11).
    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    // A result pulse lasts one cycle (R11).
    p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |=> !(done || err));

    // An error code is present exactly when an error is reported (R11).
    p_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != RES_OK) == err);

    // A calibration timeout leaves the DLL disabled (R6).
    p_cal_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err && err_code == RES_CAL_TMO) |-> !dll_en);

endmodule

// File: tb/tb_phyup_seq.sv
module tb_phyup_seq;
    localparam int CPU   = 2;
    localparam int S_CYC = 3 * CPU;
    localparam int C_CYC = 50 * CPU;
    localparam int L_CYC = 1 * 1000 * CPU;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_on = 1'b0;
    logic [31:0] rate_hz = '0;
    logic        cal_done = 1'b0;
    logic        dll_ready = 1'b0;
    logic        pwr_up, dll_en, rate_warn, done, err;
    logic [1:0]  freq_band, err_code;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    phyup_seq #(
        .REF_CYC_PER_US(CPU), .SETTLE_US(3), .CAL_TO_US(50), .LOCK_TO_MS(1), .RATE_W(32)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_on(req_on),
        .rate_hz(rate_hz), .cal_done(cal_done), .dll_ready(dll_ready),
        .pwr_up(pwr_up), .dll_en(dll_en), .freq_band(freq_band),
        .rate_warn(rate_warn), .done(done), .err(err), .err_code(err_code)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_band(input longint r);
        if (r == 0) return 0;
        if (r < 75_000_000) return 1;
        if (r < 125_000_000) return 2;
        if (r < 175_000_000) return 3;
        return 0;
    endfunction

    function automatic bit exp_warn(input longint r);
        longint c, d;
        case (exp_band(r))
            1: c = 50_000_000;
            2: c = 100_000_000;
            3: c = 150_000_000;
            default: c = 200_000_000;
        endcase
        d = (r > c) ? r - c : c - r;
        return ((r > 50_000_000) && (d > 15_000_000)) || (r > 200_000_000);
    endfunction

    // Present one request for a single accepting edge; returns at the next falling edge.
    task automatic send(input bit on, input logic [31:0] r);
        req_valid = 1'b1; req_on = on; rate_hz = r;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    // R3/R10: power-on settle timing, with an optional ignored request during settle.
    task automatic wait_settle(input bit poke);
        chk(!pwr_up && !dll_en, "R3 lines low after accept", pwr_up, 0);
        for (int k = 1; k < S_CYC; k++) begin
            if (poke && k == 2) begin
                req_valid = 1'b1; req_on = 1'b0;
            end
            step();
            req_valid = 1'b0;
            if (poke && k == 2) chk(!done, "R10 request ignored while busy", done, 0);
        end
        chk(!pwr_up, "R3 pwr_up still low one cycle early", pwr_up, 0);
        step();
        chk(pwr_up, "R3 pwr_up rises after settle", pwr_up, 1);
    endtask

    // Complete power-on sequence with calibration and (if rate nonzero) lock.
    task automatic power_on_ok(input logic [31:0] r, input bit poke);
        send(1'b1, r);
        chk(rate_warn == exp_warn(r), "R5 rate_warn", rate_warn, exp_warn(r));
        wait_settle(poke);
        cal_done = 1'b1;
        step();
        chk(freq_band == exp_band(r), "R4 freq_band", freq_band, exp_band(r));
        chk(!dll_en, "R7 band before dll_en", dll_en, 0);
        step();
        chk(dll_en, "R7 dll_en after band", dll_en, 1);
        if (r == 0) begin
            chk(done && err_code == 0, "R8 done with dll_en at zero rate", done, 1);
        end else begin
            chk(!done, "R9 no done before lock", done, 0);
            repeat (3) step();
            chk(!done && !err, "R9 still waiting for lock", done, 0);
            dll_ready = 1'b1;
            step();
            chk(done && !err && err_code == 0, "R9 done after lock", done, 1);
            chk(freq_band == exp_band(r), "R7 band held", freq_band, exp_band(r));
        end
        step();
        chk(!done && !err, "R11 pulse one cycle", done, 0);
        cal_done = 1'b0; dll_ready = 1'b0;
    endtask

    task automatic t_reset();
        chk(!pwr_up && !dll_en && freq_band == 0 && !rate_warn && !done && !err && err_code == 0,
            "R1 reset state", {pwr_up, dll_en, freq_band, rate_warn, done, err, err_code}, 0);
    endtask

    task automatic t_off();
        logic [1:0] b;
        b = freq_band;
        send(1'b0, 32'd100_000_000);
        chk(!pwr_up && !dll_en, "R2 lines low on off", {pwr_up, dll_en}, 0);
        chk(done && !err && err_code == 0, "R2 off done pulse", done, 1);
        chk(!rate_warn, "R5 off clears warn", rate_warn, 0);
        chk(freq_band == b, "R2 band unchanged", freq_band, b);
        step();
        chk(!done, "R11 off pulse one cycle", done, 0);
    endtask

    task automatic t_cal_timeout();
        int k;
        logic [1:0] b;
        b = freq_band;
        send(1'b1, 32'd100_000_000);
        wait_settle(1'b0);
        k = 0;
        while (!err && k < C_CYC + 5) begin step(); k++; end
        chk(k == C_CYC, "R6 cal timeout cycles", k, C_CYC);
        chk(err_code == 1 && !done, "R6 cal error code", err_code, 1);
        chk(!dll_en && freq_band == b, "R6 dll_en low, band kept", dll_en, 0);
        step();
    endtask

    task automatic t_lock_timeout();
        int k;
        send(1'b1, 32'd150_000_000);
        wait_settle(1'b0);
        cal_done = 1'b1;
        step(); step();
        chk(dll_en, "R7 dll_en on before lock wait", dll_en, 1);
        k = 0;
        while (!err && k < L_CYC + 5) begin step(); k++; end
        chk(k == L_CYC, "R9 lock timeout cycles", k, L_CYC);
        chk(err_code == 2 && !done, "R9 lock error code", err_code, 2);
        cal_done = 1'b0;
        step();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step();
        t_off();
        power_on_ok(32'd50_000_000, 1'b0);
        power_on_ok(32'd70_000_000, 1'b0);
        power_on_ok(32'd10_000_000, 1'b1);
        power_on_ok(32'd74_999_999, 1'b0);
        power_on_ok(32'd75_000_000, 1'b0);
        power_on_ok(32'd120_000_000, 1'b0);
        power_on_ok(32'd174_999_999, 1'b0);
        power_on_ok(32'd175_000_000, 1'b0);
        power_on_ok(32'd200_000_000, 1'b0);
        power_on_ok(32'd210_000_000, 1'b0);
        power_on_ok(32'd0, 1'b0);
        t_off();
        t_cal_timeout();
        t_lock_timeout();
        t_off();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule